// File: doc/BRIEF.md
# Masked Pixel Merge and Conditional Write Engine

This block sits between a host write port and a display memory that holds 12 bits per pixel. Each accepted host write becomes one pixel update. The update can be a plain replacement. It can also be a read-modify-write that merges the new value into the stored pixel with OR, AND or XOR. A third kind is a conditional replacement, where each 4-bit colour subfield is written only if an equality or inequality test against a programmable compare value holds. That test looks at either the stored pixel or the incoming data.

A per-bit protect mask limits every update. Protected bits never reach the memory's per-bit write enable. Modes that need the stored pixel issue one read cycle before the write cycle. The block asserts `busy` from the cycle after acceptance until the write cycle ends, and it ignores host strobes during that time. The block does no addressing. It pulses `addr_adv` once per accepted write, so that an external address counter can step forward.

Top module: `pixop_unit`

## Requirements
- R1: While reset is held and whenever the block is idle, `busy`, `ram_rd`, `ram_wr` and `addr_adv` are all 0.
- R2: A `mask` bit of 1 forces the matching `ram_bit_en` bit to 0, so that memory bit keeps its value. A mask bit of 0 allows the write.
- R3: Mode 3'b000 writes `wr_data` to all unmasked bits. It issues no read, and its write cycle is the first cycle after the accepting edge.
- R4: Modes 3'b001, 3'b010 and 3'b011 read the stored pixel (`ram_rd` in the first cycle after acceptance, data returned one cycle later). They then write stored OR new, stored AND new, or stored XOR new in the second cycle.
- R5: Mode 3'b100 writes the new data only into subfields [11:8], [7:4] and [3:0] whose stored value equals the matching subfield of `cmp_val`. Mode 3'b101 writes only where they differ. Both modes use a read cycle first.
- R6: Mode 3'b110 writes only subfields where the new data equals `cmp_val`. Mode 3'b111 writes only where they differ. Neither mode issues a read.
- R7: `busy` is 1 from the cycle after acceptance through the write cycle. A `wr_stb` seen while `busy` is 1 is ignored and causes no extra read, write or address step.
- R8: `addr_adv` is a single-cycle pulse in the write cycle of every accepted write, even when no bit gets written.
- R9: `ram_wr` is 1 only in a write cycle in which at least one bit is enabled.
- R10: Mode, data, mask and compare value are captured at the accepting edge. Changes to them while `busy` is 1 have no effect on the pending update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_stb | input | 1 | Host write request, accepted when not busy |
| wr_data | input | 12 | New pixel value |
| mode | input | 3 | Update mode code |
| mask | input | 12 | Per-bit protect mask, 1 = keep |
| cmp_val | input | 12 | Compare value for conditional modes |
| ram_rdata | input | 12 | Stored pixel, valid the cycle after `ram_rd` |
| busy | output | 1 | Update in progress |
| ram_rd | output | 1 | Memory read strobe |
| ram_wr | output | 1 | Memory write strobe |
| ram_bit_en | output | 12 | Per-bit write enable |
| ram_wdata | output | 12 | Data to write |
| addr_adv | output | 1 | Address step pulse |

## Verification
The hardest situation to reach from the ports is a host strobe that arrives in the middle of a read-modify-write, combined with configuration inputs that change at the same moment. To get there, the bench keeps `wr_stb` high through the read and write cycles and, at the same time, replaces the mode, data and mask with values that would give a visibly different pixel. It then checks that the memory holds the result of the first request and that only one address step occurred. The conditional modes are driven with compare values that match only some subfields, so partial enables and the case with no enabled bit are both covered.

// File: rtl/pixop_pkg.sv
package pixop_pkg;

  typedef enum logic [2:0] {
    OP_REPLACE = 3'd0,
    OP_OR      = 3'd1,
    OP_AND     = 3'd2,
    OP_XOR     = 3'd3,
    OP_EQ_OLD  = 3'd4,
    OP_NE_OLD  = 3'd5,
    OP_EQ_NEW  = 3'd6,
    OP_NE_NEW  = 3'd7
  } pix_op_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_READ  = 2'd1,
    PH_WRITE = 2'd2
  } phase_e;

  // Modes that need the stored pixel before writing
  function automatic logic op_reads_old(input pix_op_e op);
    case (op)
      OP_OR, OP_AND, OP_XOR, OP_EQ_OLD, OP_NE_OLD: return 1'b1;
      default:                                     return 1'b0;
    endcase
  endfunction

  function automatic logic op_is_cond(input pix_op_e op);
    return op[2];
  endfunction

  function automatic logic op_tests_new(input pix_op_e op);
    return (op == OP_EQ_NEW) || (op == OP_NE_NEW);
  endfunction

  // Even codes among the conditional modes test equality
  function automatic logic op_wants_equal(input pix_op_e op);
    return ~op[0];
  endfunction

endpackage

// File: rtl/pixop_capture.sv
module pixop_capture
  import pixop_pkg::*;
#(
  parameter int PIX_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [PIX_W-1:0] data_in,
  input  logic [2:0]       op_in,
  input  logic [PIX_W-1:0] mask_in,
  input  logic [PIX_W-1:0] cmp_in,
  output logic [PIX_W-1:0] data_q,
  output pix_op_e          op_q,
  output logic [PIX_W-1:0] mask_q,
  output logic [PIX_W-1:0] cmp_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q <= '0;
      op_q   <= OP_REPLACE;
      mask_q <= '0;
      cmp_q  <= '0;
    end else if (load) begin
      data_q <= data_in;
      op_q   <= pix_op_e'(op_in);
      mask_q <= mask_in;
      cmp_q  <= cmp_in;
    end
  end

endmodule

// File: rtl/pixop_seq.sv
module pixop_seq
  import pixop_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_stb,
  input  logic needs_read,
  output logic busy,
  output logic accept,
  output logic rd_phase,
  output logic wr_phase
);

  phase_e state_q, state_d;

  assign accept   = wr_stb && (state_q == PH_IDLE);
  assign busy     = (state_q != PH_IDLE);
  assign rd_phase = (state_q == PH_READ);
  assign wr_phase = (state_q == PH_WRITE);

  always_comb begin
    state_d = state_q;
    case (state_q)
      PH_IDLE:  if (wr_stb) state_d = needs_read ? PH_READ : PH_WRITE;
      PH_READ:  state_d = PH_WRITE;
      PH_WRITE: state_d = PH_IDLE;
      default:  state_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= PH_IDLE;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/pixop_merge.sv
module pixop_merge
  import pixop_pkg::*;
#(
  parameter int PIX_W = 12,
  parameter int SUB_W = 4
) (
  input  pix_op_e          op,
  input  logic [PIX_W-1:0] new_d,
  input  logic [PIX_W-1:0] old_d,
  input  logic [PIX_W-1:0] cmp,
  input  logic [PIX_W-1:0] mask,
  output logic [PIX_W-1:0] wdata,
  output logic [PIX_W-1:0] bit_en
);

  localparam int NSUB = PIX_W / SUB_W;

  function automatic logic [PIX_W-1:0] combine(input pix_op_e o,
                                               input logic [PIX_W-1:0] stored,
                                               input logic [PIX_W-1:0] incoming);
    case (o)
      OP_OR:   return stored | incoming;
      OP_AND:  return stored & incoming;
      OP_XOR:  return stored ^ incoming;
      default: return incoming;
    endcase
  endfunction

  function automatic logic sub_pass(input logic [SUB_W-1:0] probe,
                                    input logic [SUB_W-1:0] ref_v,
                                    input logic want_eq);
    return want_eq ? (probe == ref_v) : (probe != ref_v);
  endfunction

  logic [PIX_W-1:0] probe;
  logic [PIX_W-1:0] cond_en;
  logic [NSUB-1:0]  sub_ok;

  assign probe = op_tests_new(op) ? new_d : old_d;

  for (genvar g = 0; g < NSUB; g++) begin : g_sub
    assign sub_ok[g] = sub_pass(probe[g*SUB_W +: SUB_W], cmp[g*SUB_W +: SUB_W],
                                op_wants_equal(op));
    assign cond_en[g*SUB_W +: SUB_W] = op_is_cond(op) ? {SUB_W{sub_ok[g]}} : {SUB_W{1'b1}};
  end

  assign wdata  = combine(op, old_d, new_d);
  assign bit_en = cond_en & ~mask;

endmodule

// File: rtl/pixop_unit.sv
module pixop_unit
  import pixop_pkg::*;
#(
  parameter int PIX_W = 12,
  parameter int SUB_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_stb,
  input  logic [PIX_W-1:0] wr_data,
  input  logic [2:0]       mode,
  input  logic [PIX_W-1:0] mask,
  input  logic [PIX_W-1:0] cmp_val,
  input  logic [PIX_W-1:0] ram_rdata,
  output logic             busy,
  output logic             ram_rd,
  output logic             ram_wr,
  output logic [PIX_W-1:0] ram_bit_en,
  output logic [PIX_W-1:0] ram_wdata,
  output logic             addr_adv
);

  logic             accept;
  logic             rd_phase;
  logic             wr_phase;
  logic             needs_read;
  logic [PIX_W-1:0] data_q;
  pix_op_e          op_q;
  logic [PIX_W-1:0] mask_q;
  logic [PIX_W-1:0] cmp_q;
  logic [PIX_W-1:0] merged;
  logic [PIX_W-1:0] en_raw;
  logic             any_bit;

  assign needs_read = op_reads_old(pix_op_e'(mode));

  pixop_seq seq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_stb     (wr_stb),
    .needs_read (needs_read),
    .busy       (busy),
    .accept     (accept),
    .rd_phase   (rd_phase),
    .wr_phase   (wr_phase)
  );

  pixop_capture #(.PIX_W(PIX_W)) cap_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept),
    .data_in (wr_data),
    .op_in   (mode),
    .mask_in (mask),
    .cmp_in  (cmp_val),
    .data_q  (data_q),
    .op_q    (op_q),
    .mask_q  (mask_q),
    .cmp_q   (cmp_q)
  );

  pixop_merge #(.PIX_W(PIX_W), .SUB_W(SUB_W)) merge_i (
    .op     (op_q),
    .new_d  (data_q),
    .old_d  (ram_rdata),
    .cmp    (cmp_q),
    .mask   (mask_q),
    .wdata  (merged),
    .bit_en (en_raw)
  );

  assign any_bit    = |en_raw;
  assign ram_rd     = rd_phase;
  assign ram_wr     = wr_phase && any_bit;
  assign ram_bit_en = wr_phase ? en_raw : '0;
  assign ram_wdata  = wr_phase ? merged : '0;
  assign addr_adv   = wr_phase;

endmodule

// File: rtl/pixop_chk.sv
module pixop_chk #(
  parameter int PIX_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             accept,
  input logic             ram_rd,
  input logic             ram_wr,
  input logic [PIX_W-1:0] ram_bit_en,
  input logic             addr_adv,
  input logic [PIX_W-1:0] mask_q
);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!ram_rd && !ram_wr && !addr_adv));

  assert_mask_guard_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ram_wr |-> ((ram_bit_en & mask_q) == '0));

  assert_read_then_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ram_rd |=> (addr_adv && !ram_rd));

  assert_accept_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);

  assert_single_adv_R8: assert property (@(posedge clk) disable iff (!rst_n)
    addr_adv |=> (!addr_adv && !busy));

  assert_wr_in_phase_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ram_wr |-> (addr_adv && (ram_bit_en != '0)));

  assert_hold_cfg_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(mask_q));

endmodule

bind pixop_unit pixop_chk #(.PIX_W(PIX_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .accept     (accept),
  .ram_rd     (ram_rd),
  .ram_wr     (ram_wr),
  .ram_bit_en (ram_bit_en),
  .addr_adv   (addr_adv),
  .mask_q     (mask_q)
);

// File: tb/pixop_unit_tb_top.sv
module pixop_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_stb = 1'b0;
  logic [11:0] wr_data = '0;
  logic [2:0]  mode = '0;
  logic [11:0] mask = '0;
  logic [11:0] cmp_val = '0;
  logic [11:0] ram_rdata = '0;
  logic        busy, ram_rd, ram_wr, addr_adv;
  logic [11:0] ram_bit_en, ram_wdata;

  logic [11:0] pix = '0;
  int n_adv = 0, n_wr = 0, n_rd = 0;
  int n_chk = 0, n_err = 0;

  always #4 clk = ~clk;

  pixop_unit dut_i (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data), .mode(mode),
    .mask(mask), .cmp_val(cmp_val), .ram_rdata(ram_rdata), .busy(busy),
    .ram_rd(ram_rd), .ram_wr(ram_wr), .ram_bit_en(ram_bit_en),
    .ram_wdata(ram_wdata), .addr_adv(addr_adv)
  );

  // One-word memory model with one cycle of read latency
  always @(posedge clk) begin
    if (ram_rd) ram_rdata <= pix;
    if (ram_wr) pix <= (pix & ~ram_bit_en) | (ram_wdata & ram_bit_en);
    if (rst_n) begin
      if (addr_adv) n_adv <= n_adv + 1;
      if (ram_wr)   n_wr  <= n_wr + 1;
      if (ram_rd)   n_rd  <= n_rd + 1;
    end
  end

  task automatic check(input string req, input string what, input int got, input int expv);
    n_chk++;
    if (got !== expv) begin
      n_err++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, got, expv);
    end
  endtask

  // Bench's own statement of the update rules, bit by bit
  function automatic logic [23:0] model(input logic [2:0] op, input logic [11:0] old,
                                        input logic [11:0] nd, input logic [11:0] m,
                                        input logic [11:0] c);
    logic [11:0] res, en;
    for (int i = 0; i < 12; i++) begin
      int  lo;
      logic nib_eq_old, nib_eq_new, ok;
      logic v;
      lo = (i / 4) * 4;
      nib_eq_old = (old[lo +: 4] == c[lo +: 4]);
      nib_eq_new = (nd[lo +: 4] == c[lo +: 4]);
      case (op)
        3'd4: ok = nib_eq_old;
        3'd5: ok = !nib_eq_old;
        3'd6: ok = nib_eq_new;
        3'd7: ok = !nib_eq_new;
        default: ok = 1'b1;
      endcase
      case (op)
        3'd1: v = old[i] | nd[i];
        3'd2: v = old[i] & nd[i];
        3'd3: v = old[i] ^ nd[i];
        default: v = nd[i];
      endcase
      en[i]  = ok && !m[i];
      res[i] = en[i] ? v : old[i];
    end
    return {en, res};
  endfunction

  task automatic do_write(input string req, input logic [2:0] op, input logic [11:0] d,
                          input logic [11:0] m, input logic [11:0] c);
    logic [23:0] r;
    logic rmw;
    int adv0, wr0, rd0;
    r    = model(op, pix, d, m, c);
    rmw  = (op >= 3'd1) && (op <= 3'd5);
    adv0 = n_adv; wr0 = n_wr; rd0 = n_rd;
    @(negedge clk);
    wr_stb = 1'b1; mode = op; wr_data = d; mask = m; cmp_val = c;
    @(negedge clk);
    wr_stb = 1'b0;
    check(req, "busy after accept", busy, 1);
    if (rmw) begin
      check(req, "read strobe", ram_rd, 1);
      check(req, "no step in read cycle", addr_adv, 0);
      @(negedge clk);
    end else begin
      check(req, "no read in direct mode", ram_rd, 0);
    end
    check(req, "address step in write cycle", addr_adv, 1);
    check(req, "bit enables", ram_bit_en, r[23:12]);
    @(negedge clk);
    check(req, "idle after write", busy, 0);
    check(req, "stored pixel", pix, r[11:0]);
    check("R8", "one step per write", n_adv - adv0, 1);
    check("R9", "write strobe count", n_wr - wr0, (r[23:12] != 0) ? 1 : 0);
    check(req, "read count", n_rd - rd0, rmw ? 1 : 0);
  endtask

  // Strobe held through a read-modify-write with new settings (R7, R10)
  task automatic stall_case();
    logic [23:0] r;
    int adv0, rd0;
    r = model(3'd1, pix, 12'h0C3, 12'h00F, 12'h000);
    adv0 = n_adv; rd0 = n_rd;
    @(negedge clk);
    wr_stb = 1'b1; mode = 3'd1; wr_data = 12'h0C3; mask = 12'h00F; cmp_val = '0;
    @(negedge clk);
    check("R7", "busy in read cycle", busy, 1);
    mode = 3'd0; wr_data = 12'h000; mask = 12'h000;
    @(negedge clk);
    check("R10", "write data uses captured settings", ram_wdata & ram_bit_en, r[11:0] & r[23:12]);
    wr_stb = 1'b0;
    @(negedge clk);
    check("R7", "idle after stalled request", busy, 0);
    check("R10", "pixel reflects first request", pix, r[11:0]);
    check("R7", "held strobe adds no step", n_adv - adv0, 1);
    check("R7", "held strobe adds no read", n_rd - rd0, 1);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL R7 watchdog: actual still running expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "busy in reset", busy, 0);
    check("R1", "strobes in reset", {ram_rd, ram_wr, addr_adv}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "idle after reset", {busy, ram_rd, ram_wr, addr_adv}, 0);

    do_write("R3", 3'd0, 12'hA5C, 12'h000, 12'h000);
    do_write("R2", 3'd0, 12'h3F1, 12'h0F0, 12'h000);
    do_write("R4", 3'd1, 12'h103, 12'h000, 12'h000);
    do_write("R4", 3'd2, 12'hF0F, 12'h00F, 12'h000);
    do_write("R4", 3'd3, 12'hFFF, 12'h800, 12'h000);
    do_write("R5", 3'd4, 12'h777, 12'h000, {pix[11:8], ~pix[7:4], ~pix[3:0]});
    do_write("R5", 3'd5, 12'h2D8, 12'h000, {pix[11:8], ~pix[7:4], pix[3:0]});
    do_write("R5", 3'd4, 12'h000, 12'h0C0, {~pix[11:8], pix[7:4], ~pix[3:0]});
    do_write("R6", 3'd6, 12'h9C3, 12'h000, 12'h903);
    do_write("R6", 3'd7, 12'h9C3, 12'h010, 12'h9A0);
    do_write("R9", 3'd6, 12'h123, 12'h000, 12'h456);
    do_write("R8", 3'd0, 12'hFFF, 12'hFFF, 12'h000);
    stall_case();
    do_write("R3", 3'd0, 12'h000, 12'h000, 12'h000);
    finish_run();
  end

endmodule